// File: doc/BRIEF.md
# DDR Sample Output Formatter

This block sits between a converter's sample path and its output pads. It takes one signed 14-bit sample on every clock edge. It picks either the live sample or a programmable constant test word. It can recode the live sample from two's complement into offset binary. It holds the chosen word for a fixed pipeline latency and then presents it on one of two output buses.

In parallel mode the whole word is driven on a 14-bit bus and changes once per clock. In double-data-rate mode the word is split into two 7-bit halves and driven on 7 lanes. One half is driven during the high phase of the forwarded clock and the other during the low phase. Two split orders are available: even/odd bits, or low/high halves. Static configuration fields select the mode and the order. They also select an optional half-cycle shift of the data, inversion of the forwarded clock, and output-enable control of the data and clock buses.

The double-data-rate output is modelled as two registered halves and a multiplexer steered by the clock level. This keeps the block synthesizable and observable on either clock phase.

Top module: `ddr_sample_fmt`

## Requirements
- R1: While reset is asserted, and before any sample has left the pipeline, every data output word is zero and both output enables are high (with all disable fields low).
- R2: A word captured at clock edge k is presented on the outputs after edge k+9 and held until edge k+10.
- R3: With cfg_ddr_en low, out_par carries the whole word for the full clock period and out_lane is zero. With cfg_ddr_en high, out_par is zero.
- R4: With cfg_ddr_en high and cfg_bytewise low, lane i carries word bit 2i while the clock is high and word bit 2i+1 while it is low.
- R5: With cfg_ddr_en high and cfg_bytewise high, lane i carries word bit i while the clock is high and word bit i+7 while it is low.
- R6: With cfg_offset_bin high, the live sample's bit 13 is inverted, which maps two's complement -8192..8191 onto 0..16383. With it low, the sample passes unchanged.
- R7: With cfg_pat_en high, the word is {cfg_pat_hi, cfg_pat_lo}, with cfg_pat_lo in bits 8..0. The format recoding of R6 is not applied to it.
- R8: With cfg_data_shift high, the output waveform is delayed by half a clock. While the clock is high, the DDR lanes show the previous word's low-phase half and the parallel bus shows the previous word. While the clock is low, the lanes show the current word's high-phase half and the parallel bus shows the current word.
- R9: out_clk equals the clock when cfg_clk_invert is low and its complement when cfg_clk_invert is high.
- R10: out_data_oe is the inverse of cfg_obuf_off. out_clk_oe is high only when both cfg_obuf_off and cfg_clkbuf_off are low. cfg_clkbuf_off leaves the data outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_sample | input | 14 | Two's complement sample, captured every rising edge |
| cfg_ddr_en | input | 1 | 1: 7-lane double-data-rate bus, 0: 14-bit parallel bus |
| cfg_bytewise | input | 1 | DDR split order, 0: even/odd bits, 1: low/high halves |
| cfg_offset_bin | input | 1 | 1: offset binary output, 0: two's complement |
| cfg_data_shift | input | 1 | Delay data transitions by half a clock |
| cfg_clk_invert | input | 1 | Invert the forwarded clock (receiver captures on the other edge) |
| cfg_obuf_off | input | 1 | Disable both data and clock outputs |
| cfg_clkbuf_off | input | 1 | Disable only the forwarded clock |
| cfg_pat_en | input | 1 | Replace live data with the test word |
| cfg_pat_lo | input | 9 | Test word bits 8..0 |
| cfg_pat_hi | input | 5 | Test word bits 13..9 |
| out_clk | output | 1 | Forwarded clock |
| out_clk_oe | output | 1 | Forwarded clock enable |
| out_lane | output | 7 | DDR data lanes |
| out_par | output | 14 | Parallel data bus |
| out_data_oe | output | 1 | Data bus enable |

## Verification
The embedded properties check on every clock edge that the idle bus of the selected mode stays at zero. They also check that the clock enable is never high without the data enable, that disabling only the clock keeps data enabled, and that the word leaving the pipeline advances by exactly one stage per clock. The exact 9-cycle latency, both lane orders, the half-cycle shift, number-format recoding and test-word substitution can only be shown by the scenarios. In those, a queue-based model reassembles the expected half-words and compares every output port in both clock phases. Mode and format changes in the middle of a stream show that recoding follows the setting at capture time, while lane steering follows the current setting.

// File: rtl/sfmt_pkg.sv
package sfmt_pkg;
   localparam int SAMPLE_W_DEF = 14;
   localparam int PAT_LO_W_DEF = 9;
   localparam int LATENCY_DEF  = 9;

   typedef enum logic {
      ORDER_EVEN_ODD = 1'b0,
      ORDER_LOW_HIGH = 1'b1
   } lane_order_e;
endpackage

// File: rtl/sfmt_word_sel.sv
module sfmt_word_sel #(
   parameter int SAMPLE_W = 14,
   parameter int PAT_LO_W = 9,
   localparam int PAT_HI_W = SAMPLE_W - PAT_LO_W
) (
   input  logic [SAMPLE_W-1:0] raw,
   input  logic                pat_en,
   input  logic                offset_bin,
   input  logic [PAT_LO_W-1:0] pat_lo,
   input  logic [PAT_HI_W-1:0] pat_hi,
   output logic [SAMPLE_W-1:0] word
);
   generate
      if (PAT_LO_W < 1 || PAT_LO_W >= SAMPLE_W) begin : g_bad_split
         $error("pattern low field must leave at least one high bit");
      end
   endgenerate

   always_comb begin
      if (pat_en) begin
         word = {pat_hi, pat_lo};
      end else begin
         word = raw;
         if (offset_bin) word[SAMPLE_W-1] = ~raw[SAMPLE_W-1];
      end
   end
endmodule

// File: rtl/sfmt_delay_line.sv
module sfmt_delay_line #(
   parameter int W     = 14,
   parameter int DEPTH = 9,
   localparam int LAST = DEPTH + 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] cur,
   output logic [W-1:0] prev
);
   logic [W-1:0] stg [0:LAST];

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("latency must be at least one cycle");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   for (genvar j = 1; j <= LAST; j++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[j] <= '0;
         else        stg[j] <= stg[j-1];
      end
   end

   assign cur  = stg[DEPTH];
   assign prev = stg[LAST];
endmodule

// File: rtl/sfmt_lane_pack.sv
module sfmt_lane_pack #(
   parameter int SAMPLE_W = 14,
   localparam int LANES = SAMPLE_W / 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] cur,
   input  logic [SAMPLE_W-1:0] prev,
   input  logic                ddr_en,
   input  logic                bytewise,
   input  logic                shift,
   output logic [LANES-1:0]    lane,
   output logic [SAMPLE_W-1:0] par
);
   import sfmt_pkg::*;

   logic [LANES-1:0] rise_cur, fall_cur, fall_prev;
   lane_order_e      order;

   generate
      if (SAMPLE_W % 2 != 0) begin : g_bad_width
         $error("sample width must be even to split over two edges");
      end
   endgenerate

   assign order = lane_order_e'(bytewise);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign rise_cur[i]  = (order == ORDER_LOW_HIGH) ? cur[i]        : cur[2*i];
      assign fall_cur[i]  = (order == ORDER_LOW_HIGH) ? cur[LANES+i]  : cur[2*i+1];
      assign fall_prev[i] = (order == ORDER_LOW_HIGH) ? prev[LANES+i] : prev[2*i+1];
   end

   always_comb begin
      lane = '0;
      par  = '0;
      if (ddr_en) begin
         if (shift) lane = clk ? fall_prev : rise_cur;
         else       lane = clk ? rise_cur  : fall_cur;
      end else begin
         par = (shift && clk) ? prev : cur;
      end
   end

   p_par_idle_in_ddr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ddr_en |-> (par == '0));
   p_lane_idle_in_par_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ddr_en |-> (lane == '0));
endmodule

// File: rtl/ddr_sample_fmt.sv
module ddr_sample_fmt #(
   parameter int SAMPLE_W = sfmt_pkg::SAMPLE_W_DEF,
   parameter int PAT_LO_W = sfmt_pkg::PAT_LO_W_DEF,
   parameter int LATENCY  = sfmt_pkg::LATENCY_DEF,
   localparam int LANES    = SAMPLE_W / 2,
   localparam int PAT_HI_W = SAMPLE_W - PAT_LO_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] in_sample,
   input  logic                cfg_ddr_en,
   input  logic                cfg_bytewise,
   input  logic                cfg_offset_bin,
   input  logic                cfg_data_shift,
   input  logic                cfg_clk_invert,
   input  logic                cfg_obuf_off,
   input  logic                cfg_clkbuf_off,
   input  logic                cfg_pat_en,
   input  logic [PAT_LO_W-1:0] cfg_pat_lo,
   input  logic [PAT_HI_W-1:0] cfg_pat_hi,
   output logic                out_clk,
   output logic                out_clk_oe,
   output logic [LANES-1:0]    out_lane,
   output logic [SAMPLE_W-1:0] out_par,
   output logic                out_data_oe
);
   logic [SAMPLE_W-1:0] fmt_word, cur_w, prev_w;

   sfmt_word_sel #(.SAMPLE_W(SAMPLE_W), .PAT_LO_W(PAT_LO_W)) u_sel (
      .raw(in_sample), .pat_en(cfg_pat_en), .offset_bin(cfg_offset_bin),
      .pat_lo(cfg_pat_lo), .pat_hi(cfg_pat_hi), .word(fmt_word));

   sfmt_delay_line #(.W(SAMPLE_W), .DEPTH(LATENCY)) u_dly (
      .clk(clk), .rst_n(rst_n), .d(fmt_word), .cur(cur_w), .prev(prev_w));

   sfmt_lane_pack #(.SAMPLE_W(SAMPLE_W)) u_pack (
      .clk(clk), .rst_n(rst_n), .cur(cur_w), .prev(prev_w),
      .ddr_en(cfg_ddr_en), .bytewise(cfg_bytewise), .shift(cfg_data_shift),
      .lane(out_lane), .par(out_par));

   assign out_clk     = clk ^ cfg_clk_invert;
   assign out_data_oe = ~cfg_obuf_off;
   assign out_clk_oe  = ~cfg_obuf_off & ~cfg_clkbuf_off;

   p_clk_oe_needs_data_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_clk_oe |-> out_data_oe);
   p_clkbuf_keeps_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_clkbuf_off && !cfg_obuf_off) |-> (out_data_oe && !out_clk_oe));
   p_pipe_advances_r2: assert property (@(posedge clk) disable iff (!rst_n)
      prev_w == $past(cur_w));
endmodule

// File: tb/ddr_sample_fmt_tb_top.sv
module ddr_sample_fmt_tb_top;
   localparam int W = 14, LANES = 7, LAT = 9;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n = 1'b0;
   logic [W-1:0] in_sample = '0;
   logic cfg_ddr_en = 0, cfg_bytewise = 0, cfg_offset_bin = 0, cfg_data_shift = 0;
   logic cfg_clk_invert = 0, cfg_obuf_off = 0, cfg_clkbuf_off = 0, cfg_pat_en = 0;
   logic [8:0] cfg_pat_lo = '0;
   logic [4:0] cfg_pat_hi = '0;
   logic out_clk, out_clk_oe, out_data_oe;
   logic [LANES-1:0] out_lane;
   logic [W-1:0] out_par;

   ddr_sample_fmt dut_i (.*);

   int n_cmp = 0, n_bad = 0;
   bit done = 0;
   logic [W-1:0] hist[$];

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic logic [W-1:0] model_word(logic [W-1:0] s);
      int v;
      if (cfg_pat_en) return {cfg_pat_hi, cfg_pat_lo};
      v = int'(s);
      if (v >= 8192) v -= 16384;       // signed value
      if (cfg_offset_bin) v += 8192;   // 0..16383
      else if (v < 0) v += 16384;
      return v[W-1:0];
   endfunction

   function automatic logic [LANES-1:0] half_of(logic [W-1:0] w, bit second);
      logic [LANES-1:0] r;
      for (int i = 0; i < LANES; i++)
         r[i] = cfg_bytewise ? w[i + (second ? LANES : 0)] : w[2*i + (second ? 1 : 0)];
      return r;
   endfunction

   task automatic check_phase(string req);
      bit hi = clk;
      logic [W-1:0] cw = hist[LAT], pw = hist[LAT+1];
      logic [LANES-1:0] el;
      logic [W-1:0] ep;
      el = '0; ep = '0;
      if (cfg_ddr_en) begin
         if (cfg_data_shift) el = hi ? half_of(pw, 1) : half_of(cw, 0);
         else                el = hi ? half_of(cw, 0) : half_of(cw, 1);
      end else begin
         ep = (cfg_data_shift && hi) ? pw : cw;
      end
      chk(req, "out_lane", 32'(out_lane), 32'(el));
      chk(req, "out_par", 32'(out_par), 32'(ep));
      chk(req, "out_clk", 32'(out_clk), 32'(hi ^ cfg_clk_invert));
      chk(req, "out_data_oe", 32'(out_data_oe), 32'(!cfg_obuf_off));
      chk(req, "out_clk_oe", 32'(out_clk_oe), 32'(!cfg_obuf_off && !cfg_clkbuf_off));
   endtask

   // enter right after a falling edge; leave one unit after the next falling edge
   task automatic step(logic [W-1:0] s, string req);
      in_sample = s;
      @(posedge clk);
      hist.push_front(model_word(s));
      #1 check_phase(req);
      @(negedge clk);
      #1 check_phase(req);
   endtask

   task automatic run_random(int n, string req);
      for (int k = 0; k < n; k++) step(W'($urandom), req);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      for (int k = 0; k < LAT + 2; k++) hist.push_front('0);
      repeat (3) @(posedge clk);
      #1 check_phase("R1");
      @(negedge clk);
      rst_n = 1'b1;
      #1 check_phase("R1");

      // R2/R3: parallel, two's complement, walking and random data
      step(14'h0001, "R2");
      for (int k = 0; k < LAT; k++) step(14'(k + 2), "R2");
      run_random(30, "R3");

      // R4: DDR even/odd
      cfg_ddr_en = 1;
      run_random(30, "R4");
      step(14'h2AAA, "R4"); step(14'h1555, "R4");

      // R5: DDR low/high halves
      cfg_bytewise = 1;
      run_random(30, "R5");
      step(14'h007F, "R5"); step(14'h3F80, "R5");

      // R6: offset binary at the range edges, in both buses
      cfg_offset_bin = 1;
      step(14'h2000, "R6"); step(14'h1FFF, "R6"); step(14'h0000, "R6"); step(14'h3FFF, "R6");
      run_random(15, "R6");
      cfg_ddr_en = 0;
      run_random(15, "R6");

      // R7: test word replaces live data, no recoding
      cfg_pat_en = 1; cfg_pat_lo = 9'h1A5; cfg_pat_hi = 5'h13;
      run_random(14, "R7");
      cfg_offset_bin = 0; cfg_pat_lo = 9'h0FF; cfg_pat_hi = 5'h1F;
      run_random(14, "R7");
      cfg_pat_en = 0;

      // R8: half-cycle data shift in every bus and order
      cfg_data_shift = 1;
      run_random(20, "R8");
      cfg_ddr_en = 1; cfg_bytewise = 0;
      run_random(20, "R8");
      cfg_bytewise = 1;
      run_random(20, "R8");
      cfg_data_shift = 0;

      // R9: forwarded clock inversion
      cfg_clk_invert = 1;
      run_random(10, "R9");
      cfg_clk_invert = 0;

      // R10: output enables; data keeps flowing with only the clock disabled
      cfg_clkbuf_off = 1;
      run_random(10, "R10");
      cfg_obuf_off = 1;
      run_random(10, "R10");
      cfg_clkbuf_off = 0;
      run_random(5, "R10");
      cfg_obuf_off = 0;
      run_random(12, "R2");

      finish_run();
   end
endmodule